// File: doc/BRIEF.md
# Fixed-Point Scaled Timestamp Counter

This block produces a free-running 64-bit timestamp for downstream timers. Internally it keeps an 88-bit accumulator split as 64 integer bits over 24 fractional bits, and only the integer part leaves the block. Every clock cycle is one input tick. While the run enable is high, each tick advances the accumulator. With scaling off the step is exactly one integer count. With scaling on the step is a 32-bit value in 8.24 fixed point held in a scale register, so the visible count can advance at any rational rate from 0 to just under 256 counts per tick.

Software, through logic outside this block, can replace either 32-bit half of the visible count with a load strobe. It can also write the scale register through a write strobe. A load also zeroes the fractional bits, so counting restarts from a whole count. Changing the scale or the scaling mode while the counter runs gives an undefined count. The block makes no attempt to compensate.

Top module: `fxts_counter`

## Requirements
- R1: After reset the timestamp is 0 and the scale register holds 0x01000000, which is one whole count per tick.
- R2: On a cycle with `run_en_i` low and no load strobe, the timestamp and the hidden fraction keep their values.
- R3: With `scale_en_i` low, each enabled cycle adds exactly 1 to the timestamp, whatever the scale register holds.
- R4: With `scale_en_i` high, each enabled cycle adds the scale register to the 88-bit accumulator, and the timestamp is bits [87:24] of it. Starting from a whole count C, the timestamp after n ticks at scale S is C + floor(n*S / 2^24).
- R5: A scale write (`scale_we_i` high) is captured at the clock edge and is used from the next tick onward.
- R6: `ld_lo_i` replaces timestamp bits [31:0] with `ld_din_i` and keeps bits [63:32]. `ld_hi_i` replaces bits [63:32] and keeps bits [31:0]. When both are high, both halves take `ld_din_i`.
- R7: Any load zeroes the 24 fractional bits.
- R8: A load strobe takes priority over the increment in the same cycle.
- R9: The timestamp wraps from all ones to zero, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; each rising edge is one tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | Counter advances while high |
| scale_en_i | input | 1 | Selects the scaled step over the unit step |
| scale_we_i | input | 1 | Write strobe for the scale register |
| scale_din_i | input | 32 | New 8.24 step value |
| ld_lo_i | input | 1 | Load the low half of the timestamp |
| ld_hi_i | input | 1 | Load the high half of the timestamp |
| ld_din_i | input | 32 | Data for either half load |
| tstamp_o | output | 64 | Integer part of the accumulator |

## Verification
A load, a step or a hold takes effect at the rising edge that samples the stimulus. The bench drives its inputs on falling edges and compares `tstamp_o` at the next falling edge, half a cycle after the update. A scale write takes one more edge before it changes the step. The bench model therefore applies the written value only after it has processed the tick of the write edge. Besides comparing against the model on every cycle, the bench checks closed-form results after runs of n ticks at a set scale, and the exact cycles around a wrap and around a load.

// File: rtl/fxts_pkg.sv
package fxts_pkg;

  // What the accumulator does on a given tick.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } fxts_act_e;

endpackage

// File: rtl/fxts_scale_reg.sv
module fxts_scale_reg #(
  parameter int unsigned SCALE_W = 32,
  parameter logic [SCALE_W-1:0] RST_VAL = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SCALE_W-1:0] din_i,
  output logic [SCALE_W-1:0] scale_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_o <= RST_VAL;
    end else if (we_i) begin
      scale_o <= din_i;
    end
  end

endmodule

// File: rtl/fxts_step_gen.sv
module fxts_step_gen #(
  parameter int unsigned INT_W   = 64,
  parameter int unsigned FRAC_W  = 24,
  parameter int unsigned SCALE_W = 32
) (
  input  logic                      scale_en_i,
  input  logic [SCALE_W-1:0]        scale_i,
  output logic [INT_W+FRAC_W-1:0]   step_o
);

  localparam int unsigned ACC_W = INT_W + FRAC_W;
  localparam logic [ACC_W-1:0] UNIT_STEP = {{(ACC_W-1){1'b0}}, 1'b1} << FRAC_W;

  // Widen the scale value to the accumulator width.
  function automatic logic [ACC_W-1:0] widen_scale(input logic [SCALE_W-1:0] s);
    logic [ACC_W-1:0] w;
    w = '0;
    for (int i = 0; i < SCALE_W; i++) begin
      if (i < ACC_W) w[i] = s[i];
    end
    return w;
  endfunction

  generate
    if (SCALE_W >= 1) begin : g_scaled
      assign step_o = scale_en_i ? widen_scale(scale_i) : UNIT_STEP;
    end else begin : g_unit
      assign step_o = UNIT_STEP;
    end
  endgenerate

endmodule

// File: rtl/fxts_accum.sv
module fxts_accum
  import fxts_pkg::*;
#(
  parameter int unsigned INT_W  = 64,
  parameter int unsigned FRAC_W = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  fxts_act_e                act_i,
  input  logic                     ld_lo_i,
  input  logic                     ld_hi_i,
  input  logic [INT_W/2-1:0]       ld_din_i,
  input  logic [INT_W+FRAC_W-1:0]  step_i,
  output logic [INT_W+FRAC_W-1:0]  acc_o
);

  localparam int unsigned ACC_W  = INT_W + FRAC_W;
  localparam int unsigned HALF_W = INT_W / 2;

  // Replace the selected halves of the integer part.
  function automatic logic [INT_W-1:0] merge_halves(
    input logic [INT_W-1:0]  cur,
    input logic [HALF_W-1:0] din,
    input logic              lo,
    input logic              hi
  );
    logic [INT_W-1:0] r;
    r = cur;
    if (lo) r[HALF_W-1:0] = din;
    if (hi) r[INT_W-1:HALF_W] = din;
    return r;
  endfunction

  logic [INT_W-1:0] int_now;
  logic [INT_W-1:0] int_loaded;
  logic [ACC_W-1:0] acc_sum;

  assign int_now    = acc_o[ACC_W-1:FRAC_W];
  assign int_loaded = merge_halves(int_now, ld_din_i, ld_lo_i, ld_hi_i);
  assign acc_sum    = acc_o + step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
    end else begin
      unique case (act_i)
        ACT_LOAD: acc_o <= {int_loaded, {FRAC_W{1'b0}}};
        ACT_STEP: acc_o <= acc_sum;
        default:  acc_o <= acc_o;
      endcase
    end
  end

endmodule

// File: rtl/fxts_counter.sv
module fxts_counter
  import fxts_pkg::*;
#(
  parameter int unsigned INT_W   = 64,
  parameter int unsigned FRAC_W  = 24,
  parameter int unsigned SCALE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_en_i,
  input  logic               scale_en_i,
  input  logic               scale_we_i,
  input  logic [SCALE_W-1:0] scale_din_i,
  input  logic               ld_lo_i,
  input  logic               ld_hi_i,
  input  logic [INT_W/2-1:0] ld_din_i,
  output logic [INT_W-1:0]   tstamp_o
);

  localparam int unsigned ACC_W = INT_W + FRAC_W;
  localparam logic [SCALE_W-1:0] SCALE_ONE = {{(SCALE_W-1){1'b0}}, 1'b1} << FRAC_W;

  // Named events, visible to the checker.
  logic             load_evt;
  logic             step_evt;
  fxts_act_e        act;
  logic [SCALE_W-1:0] scale_q;
  logic [ACC_W-1:0]   step;
  logic [ACC_W-1:0]   acc_q;
  logic [FRAC_W-1:0]  frac_q;

  assign load_evt = ld_lo_i | ld_hi_i;
  assign step_evt = run_en_i & ~load_evt;

  always_comb begin
    if (load_evt)      act = ACT_LOAD;
    else if (run_en_i) act = ACT_STEP;
    else               act = ACT_HOLD;
  end

  fxts_scale_reg #(
    .SCALE_W (SCALE_W),
    .RST_VAL (SCALE_ONE)
  ) u_scale (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (scale_we_i),
    .din_i   (scale_din_i),
    .scale_o (scale_q)
  );

  fxts_step_gen #(
    .INT_W   (INT_W),
    .FRAC_W  (FRAC_W),
    .SCALE_W (SCALE_W)
  ) u_step (
    .scale_en_i (scale_en_i),
    .scale_i    (scale_q),
    .step_o     (step)
  );

  fxts_accum #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
  ) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (act),
    .ld_lo_i  (ld_lo_i),
    .ld_hi_i  (ld_hi_i),
    .ld_din_i (ld_din_i),
    .step_i   (step),
    .acc_o    (acc_q)
  );

  assign tstamp_o = acc_q[ACC_W-1:FRAC_W];
  assign frac_q   = acc_q[FRAC_W-1:0];

endmodule

// File: rtl/fxts_counter_chk.sv
module fxts_counter_chk #(
  parameter int unsigned INT_W   = 64,
  parameter int unsigned FRAC_W  = 24,
  parameter int unsigned SCALE_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               run_en_i,
  input logic               scale_en_i,
  input logic               scale_we_i,
  input logic [SCALE_W-1:0] scale_din_i,
  input logic               ld_lo_i,
  input logic               ld_hi_i,
  input logic [INT_W/2-1:0] ld_din_i,
  input logic [INT_W-1:0]   tstamp_o,
  input logic [SCALE_W-1:0] scale_q,
  input logic [FRAC_W-1:0]  frac_q,
  input logic               load_evt,
  input logic               step_evt
);

  localparam int unsigned HALF_W = INT_W / 2;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_evt && !load_evt) |=> ($stable(tstamp_o) && $stable(frac_q))); // R2

  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_i && !scale_en_i && !ld_lo_i && !ld_hi_i) |=> (tstamp_o == $past(tstamp_o) + 1'b1)); // R3

  AST_SCALED_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_evt && scale_en_i) |=>
      ((tstamp_o - $past(tstamp_o)) ==
       ((INT_W'($past(frac_q)) + INT_W'($past(scale_q))) >> FRAC_W))); // R4

  AST_SCALE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scale_we_i |=> (scale_q == $past(scale_din_i))); // R5

  AST_LOAD_LO_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo_i && !ld_hi_i) |=> ((tstamp_o[HALF_W-1:0] == $past(ld_din_i)) &&
                               (tstamp_o[INT_W-1:HALF_W] == $past(tstamp_o[INT_W-1:HALF_W])))); // R6

  AST_LOAD_HI_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_hi_i && !ld_lo_i) |=> ((tstamp_o[INT_W-1:HALF_W] == $past(ld_din_i)) &&
                               (tstamp_o[HALF_W-1:0] == $past(tstamp_o[HALF_W-1:0])))); // R6

  AST_LOAD_FRAC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_evt |=> (frac_q == '0)); // R7

  AST_LOAD_OVER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo_i && ld_hi_i && run_en_i) |=> (tstamp_o == {$past(ld_din_i), $past(ld_din_i)})); // R8

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_evt && !scale_en_i && (&tstamp_o)) |=> (tstamp_o == '0)); // R9

endmodule

bind fxts_counter fxts_counter_chk #(
  .INT_W   (INT_W),
  .FRAC_W  (FRAC_W),
  .SCALE_W (SCALE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_en_i    (run_en_i),
  .scale_en_i  (scale_en_i),
  .scale_we_i  (scale_we_i),
  .scale_din_i (scale_din_i),
  .ld_lo_i     (ld_lo_i),
  .ld_hi_i     (ld_hi_i),
  .ld_din_i    (ld_din_i),
  .tstamp_o    (tstamp_o),
  .scale_q     (scale_q),
  .frac_q      (frac_q),
  .load_evt    (load_evt),
  .step_evt    (step_evt)
);

// File: tb/fxts_counter_bench.sv
module fxts_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        scale_en = 1'b0;
  logic        scale_we = 1'b0;
  logic [31:0] scale_din = '0;
  logic        ld_lo = 1'b0;
  logic        ld_hi = 1'b0;
  logic [31:0] ld_din = '0;
  logic [63:0] tstamp;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  int unsigned cycles = 0;
  string       cur_req = "R1";
  bit          cmp_on = 1'b0;
  bit          done = 1'b0;

  // Bench model: integer part and fraction kept apart.
  logic [63:0] m_int;
  logic [23:0] m_frac;
  logic [31:0] m_scale;

  always #10 clk = ~clk; // 50 MHz

  fxts_counter u_fxts_counter (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .run_en_i    (run_en),
    .scale_en_i  (scale_en),
    .scale_we_i  (scale_we),
    .scale_din_i (scale_din),
    .ld_lo_i     (ld_lo),
    .ld_hi_i     (ld_hi),
    .ld_din_i    (ld_din),
    .tstamp_o    (tstamp)
  );

  always @(posedge clk) begin
    logic [24:0] f;
    logic [31:0] nxt_scale;
    if (!rst_n) begin
      m_int = '0; m_frac = '0; m_scale = 32'h0100_0000;
    end else begin
      nxt_scale = scale_we ? scale_din : m_scale;
      if (ld_lo || ld_hi) begin
        if (ld_lo) m_int[31:0]  = ld_din;
        if (ld_hi) m_int[63:32] = ld_din;
        m_frac = '0;
      end else if (run_en) begin
        if (scale_en) begin
          f = {1'b0, m_frac} + {1'b0, m_scale[23:0]};
          m_frac = f[23:0];
          m_int = m_int + 64'(m_scale[31:24]) + 64'(f[24]);
        end else begin
          m_int = m_int + 64'd1;
        end
      end
      m_scale = nxt_scale;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && cmp_on) check(cur_req, tstamp, m_int);
    if (cycles > 100000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic load64(input logic [63:0] v);
    @(negedge clk); ld_lo = 1; ld_hi = 0; ld_din = v[31:0];
    @(negedge clk); ld_lo = 0; ld_hi = 1; ld_din = v[63:32];
    @(negedge clk); ld_hi = 0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", tstamp, 64'd0);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    check("R1", tstamp, 64'd0);

    // R1: reset scale is one count per tick
    cur_req = "R1"; scale_en = 1; run_en = 1;
    repeat (10) @(negedge clk);
    check("R1", tstamp, 64'd10);
    run_en = 0;

    // R3: unit step ignores the scale register
    cur_req = "R3";
    scale_we = 1; scale_din = 32'h0000_0003;
    @(negedge clk); scale_we = 0; scale_en = 0; run_en = 1;
    repeat (20) @(negedge clk);
    check("R3", tstamp, 64'd30);
    run_en = 0;

    // R2: hold with fraction kept
    cur_req = "R2";
    load64(64'd0);
    scale_we = 1; scale_din = 32'h0080_0000;
    @(negedge clk); scale_we = 0; scale_en = 1; run_en = 1;
    @(negedge clk); run_en = 0;
    repeat (5) @(negedge clk);
    check("R2", tstamp, 64'd0);
    run_en = 1;
    @(negedge clk); run_en = 0;
    check("R2", tstamp, 64'd1);

    // R4: sweep of scales, closed form after n ticks
    cur_req = "R4";
    for (int i = 0; i < 24; i++) begin
      logic [31:0] s;
      int unsigned n;
      s = (i == 22) ? 32'hFFFF_FFFF : (i == 23) ? 32'h0 : 32'(i) * 32'h00B3_3335 + 32'd1;
      n = 17 + i * 5;
      @(negedge clk);
      ld_lo = 1; ld_hi = 1; ld_din = '0; scale_we = 1; scale_din = s; run_en = 0;
      @(negedge clk);
      ld_lo = 0; ld_hi = 0; scale_we = 0; scale_en = 1; run_en = 1;
      repeat (n) @(negedge clk);
      run_en = 0;
      check("R4", tstamp, (64'(n) * 64'(s)) >> 24);
    end

    // R5: written scale applies from the following tick
    cur_req = "R5";
    load64(64'd100);
    scale_en = 1; run_en = 1; scale_we = 1; scale_din = 32'h0500_0000;
    @(negedge clk); scale_we = 0;
    check("R5", tstamp, 64'd100 + ((64'(32'hFFFF_FFFF) * 64'd0) >> 24) + 64'd0);
    @(negedge clk);
    check("R5", tstamp, 64'd105);
    run_en = 0;

    // R6: half loads
    cur_req = "R6";
    load64(64'hAAAA_BBBB_CCCC_DDDD);
    check("R6", tstamp, 64'hAAAA_BBBB_CCCC_DDDD);
    @(negedge clk); ld_lo = 1; ld_din = 32'h1234_5678;
    @(negedge clk); ld_lo = 0;
    check("R6", tstamp, 64'hAAAA_BBBB_1234_5678);
    ld_hi = 1; ld_din = 32'h9ABC_DEF0;
    @(negedge clk); ld_hi = 0;
    check("R6", tstamp, 64'h9ABC_DEF0_1234_5678);
    ld_lo = 1; ld_hi = 1; ld_din = 32'h0F0F_0F0F;
    @(negedge clk); ld_lo = 0; ld_hi = 0;
    check("R6", tstamp, 64'h0F0F_0F0F_0F0F_0F0F);

    // R7: load zeroes the fraction
    cur_req = "R7";
    scale_we = 1; scale_din = 32'h0080_0000;
    @(negedge clk); scale_we = 0; scale_en = 1; run_en = 1;
    @(negedge clk); run_en = 0; ld_lo = 1; ld_din = 32'd500;
    @(negedge clk); ld_lo = 0; run_en = 1;
    @(negedge clk);
    check("R7", tstamp[31:0], 64'd500);
    @(negedge clk); run_en = 0;
    check("R7", tstamp[31:0], 64'd501);

    // R8: load wins over step in the same cycle
    cur_req = "R8";
    scale_en = 0; run_en = 1; ld_lo = 1; ld_din = 32'd77;
    @(negedge clk); ld_lo = 0; run_en = 0;
    check("R8", tstamp[31:0], 64'd77);

    // R9: wrap to zero
    cur_req = "R9";
    load64(64'hFFFF_FFFF_FFFF_FFFE);
    scale_en = 0; run_en = 1;
    @(negedge clk); check("R9", tstamp, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk); check("R9", tstamp, 64'd0);
    @(negedge clk); check("R9", tstamp, 64'd1);
    run_en = 0;

    // R9: scaled wrap
    load64(64'hFFFF_FFFF_FFFF_FFFF);
    scale_we = 1; scale_din = 32'h0300_0000;
    @(negedge clk); scale_we = 0; scale_en = 1; run_en = 1;
    @(negedge clk); run_en = 0;
    check("R9", tstamp, 64'd2);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule